// File: doc/BRIEF.md
# Serial Protected-Memory Pad Controller

This block sits behind the contacts of a bit-serial protected memory card. It watches three slow control pads (reset, clock and program) and one data pad, and turns their edges into actions on a single bit-address counter and a bit-wide register array of 1376 cells. A falling reset pad returns the counter to zero. A falling clock pad, with program low, steps it by one. A clock high phase entered with program high writes one bit. The write programs the cell to 0 or erases it to 1, whichever level the data pad held at the rising edge.

Every pad is brought into the system clock domain through a synchroniser chain and edge-detected before any decoding. The data output behaves like an open-drain pin. It is driven only where the current address may be read, and it is released (seen as 1) everywhere else. Read, program and erase rights come from a fixed zone map. They depend on the current address, a personalised flag, a security-code-validated flag, an erase-key-validated flag, and two control bits held in the first two cells of the application zone. The validation sequences themselves are outside the block and arrive as level inputs.

In the security-code and erase-key ranges, the clock/program encoding 0/0 also compares the presented data bit against the stored bit. A mismatch raises a sticky flag for the validation logic outside the block.

Top module: `serial_secmem_ctrl`

## Requirements
- R1: After rst_ni is released with all pads low, the address is 0, the array holds all ones, io_oe_o is 1, io_o is 1 and cmp_miss_o is 0.
- R2: A falling edge on the reset pad sets the address to 0 and clears cmp_miss_o.
- R3: With the reset pad and program pad low, each falling clock-pad edge advances the address by one, and io_o/io_oe_o then present the new cell.
- R4: While the reset pad is high, clock-pad edges leave the address unchanged.
- R5: The step after address MAX_ADDR (1519) returns the address to 0.
- R6: At addresses 1376 to 1519, and wherever reading is forbidden, io_oe_o is 0 and io_o is 1.
- R7: Read rights: addresses 0–79, 96–175 and 1232–1375 are always readable. The code range 80–95 and key range 1200–1231 are readable only when personalized_i=0 and code_ok_i=1. The application zone 176–1199 is readable when code_ok_i=1, or when personalized_i=1 and cell 177 is 1.
- R8: A clock-pad rising edge with program high and reset low latches the data pad as the write value (0 = program, 1 = erase). If the clock pad then stays high for at least PROG_CYCLES system clocks, the falling edge stores the value into the addressed cell when permitted. That falling edge does not move the address.
- R9: A write whose clock-pad high phase is shorter than PROG_CYCLES leaves the cell unchanged.
- R10: Write rights: 0–15 never. 16–79 and 1200–1231 need personalized_i=0 and code_ok_i=1. 80–95 and 112–175 need code_ok_i. 96–111 programs always and erases with code_ok_i. 1232–1359 programs always and erases with personalized_i=0 and code_ok_i=1. 1360–1375 always. In 176–1199, program needs code_ok_i and (personalized_i=0 or cell 176 = 1), and erase needs code_ok_i and (personalized_i=0 or erase_ok_i=1).
- R11: In 80–95 and 1200–1231, a clock-pad rising edge with program and reset low compares the data pad to the stored cell. A mismatch sets cmp_miss_o until the next reset-pad fall, and the address still steps on the following fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pad_rst_i | input | 1 | Reset pad |
| pad_clk_i | input | 1 | Clock pad |
| pad_pgm_i | input | 1 | Program pad |
| pad_io_i | input | 1 | Data pad as seen at the contact |
| personalized_i | input | 1 | Card has left personalisation |
| code_ok_i | input | 1 | Security code validated |
| erase_ok_i | input | 1 | Application erase key validated |
| io_o | output | 1 | Data output level, 1 when released |
| io_oe_o | output | 1 | Data output enable |
| cmp_miss_o | output | 1 | Sticky compare mismatch |

## Verification
The bench builds a bit pattern in the issuer zone so that a controller that steps while the reset pad is high, or misses the reset-pad clear, lands on a cell of a different value. It times a write just short of and well beyond the programming window; a design that commits on any clock fall would corrupt the cell on the short write. It walks the counter past the end of the array and through the wrap, where a counter without the wrap would show a released output at what should be address 0. It also walks the permission corners, namely the protect bit, the read-enable bit, the erase key and personalisation, where a swapped control bit opens or closes the wrong cell.

// File: rtl/secmem_pkg.sv
package secmem_pkg;

  localparam logic [15:0] ISS_LO = 16'd16;
  localparam logic [15:0] CODE_LO = 16'd80;
  localparam logic [15:0] TRY_LO = 16'd96;
  localparam logic [15:0] CPZ_LO = 16'd112;
  localparam logic [15:0] APP_LO = 16'd176;
  localparam logic [15:0] KEY_LO = 16'd1200;
  localparam logic [15:0] ERC_LO = 16'd1232;
  localparam logic [15:0] TST_LO = 16'd1360;
  localparam logic [15:0] MAP_END = 16'd1376;

  localparam int unsigned MAP_BITS = 1376;
  localparam int unsigned PROT_BIT = 176;
  localparam int unsigned RDEN_BIT = 177;

  typedef enum logic [3:0] {
    Z_FAB, Z_ISS, Z_CODE, Z_TRY, Z_CPZ, Z_APP, Z_KEY, Z_ERC, Z_TST, Z_NONE
  } zone_e;

  function automatic zone_e zone_of(input logic [15:0] a);
    if (a < ISS_LO) return Z_FAB;
    if (a < CODE_LO) return Z_ISS;
    if (a < TRY_LO) return Z_CODE;
    if (a < CPZ_LO) return Z_TRY;
    if (a < APP_LO) return Z_CPZ;
    if (a < KEY_LO) return Z_APP;
    if (a < ERC_LO) return Z_KEY;
    if (a < TST_LO) return Z_ERC;
    if (a < MAP_END) return Z_TST;
    return Z_NONE;
  endfunction

endpackage

// File: rtl/secmem_pad_sync.sv
module secmem_pad_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= {sh_q[STAGES-2:0], d_i[i]};
    end
    assign q_o[i] = sh_q[STAGES-1];
  end

endmodule

// File: rtl/secmem_addr_ctr.sv
module secmem_addr_ctr #(
  parameter int unsigned MAX_ADDR = 1519,
  localparam int unsigned ADDR_W  = $clog2(MAX_ADDR + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o
);

  localparam logic [ADDR_W-1:0] TOP = ADDR_W'(MAX_ADDR);

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         addr_q <= '0;
    else if (clear_i)    addr_q <= '0;
    else if (step_i) begin
      if (addr_q == TOP) addr_q <= '0;
      else               addr_q <= addr_q + 1'b1;
    end
  end

  assign addr_o = addr_q;

endmodule

// File: rtl/secmem_prog_timer.sv
module secmem_prog_timer #(
  parameter int unsigned PROG_CYCLES = 1_000_000,
  localparam int unsigned CNT_W      = $clog2(PROG_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic tick_i,
  input  logic stop_i,
  input  logic abort_i,
  output logic active_o,
  output logic done_o
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(PROG_CYCLES);

  logic             active_q;
  logic [CNT_W-1:0] cnt_q;

  assign done_o   = (cnt_q >= LIMIT);
  assign active_o = active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (abort_i || stop_i) begin
      active_q <= 1'b0;
    end else if (start_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (active_q && tick_i && !done_o) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/secmem_access_map.sv
module secmem_access_map #(
  parameter int unsigned ADDR_W = 11
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              pers_i,
  input  logic              code_i,
  input  logic              ekey_i,
  input  logic              prot_bit_i,
  input  logic              rden_bit_i,
  output logic              in_map_o,
  output logic              cmp_zone_o,
  output logic              rd_ok_o,
  output logic              prog_ok_o,
  output logic              ers_ok_o
);
  import secmem_pkg::*;

  zone_e zone;
  logic  perso;

  assign zone  = zone_of(16'(addr_i));
  assign perso = !pers_i && code_i;

  always_comb begin
    in_map_o   = 1'b1;
    cmp_zone_o = 1'b0;
    rd_ok_o    = 1'b1;
    prog_ok_o  = 1'b0;
    ers_ok_o   = 1'b0;
    unique case (zone)
      Z_FAB: ;
      Z_ISS: begin prog_ok_o = perso; ers_ok_o = perso; end
      Z_CODE: begin
        cmp_zone_o = 1'b1;
        rd_ok_o    = perso;
        prog_ok_o  = code_i;
        ers_ok_o   = code_i;
      end
      Z_TRY: begin prog_ok_o = 1'b1; ers_ok_o = code_i; end
      Z_CPZ: begin prog_ok_o = code_i; ers_ok_o = code_i; end
      Z_APP: begin
        rd_ok_o   = code_i || (pers_i && rden_bit_i);
        prog_ok_o = code_i && (!pers_i || prot_bit_i);
        ers_ok_o  = code_i && (!pers_i || ekey_i);
      end
      Z_KEY: begin
        cmp_zone_o = 1'b1;
        rd_ok_o    = perso;
        prog_ok_o  = perso;
        ers_ok_o   = perso;
      end
      Z_ERC: begin prog_ok_o = 1'b1; ers_ok_o = perso; end
      Z_TST: begin prog_ok_o = 1'b1; ers_ok_o = 1'b1; end
      default: begin in_map_o = 1'b0; rd_ok_o = 1'b0; end
    endcase
  end

endmodule

// File: rtl/serial_secmem_ctrl.sv
module serial_secmem_ctrl #(
  parameter int unsigned PROG_CYCLES = 1_000_000,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MAX_ADDR    = 1519
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pad_rst_i,
  input  logic pad_clk_i,
  input  logic pad_pgm_i,
  input  logic pad_io_i,
  input  logic personalized_i,
  input  logic code_ok_i,
  input  logic erase_ok_i,
  output logic io_o,
  output logic io_oe_o,
  output logic cmp_miss_o
);
  import secmem_pkg::*;

  localparam int unsigned ADDR_W   = $clog2(MAX_ADDR + 1);
  localparam int unsigned MEM_BITS = MAP_BITS;

  // s[0]=rst s[1]=clk s[2]=pgm s[3]=io
  logic [3:0] s;
  logic [2:0] prev_q;

  secmem_pad_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({pad_io_i, pad_pgm_i, pad_clk_i, pad_rst_i}),
    .q_o   (s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= s[2:0];
  end

  logic rst_s, clk_s, pgm_s, io_s;
  logic rst_fall, clk_rise, clk_fall;
  assign rst_s    = s[0];
  assign clk_s    = s[1];
  assign pgm_s    = s[2];
  assign io_s     = s[3];
  assign rst_fall = prev_q[0] && !rst_s;
  assign clk_rise = !prev_q[1] && clk_s;
  assign clk_fall = prev_q[1] && !clk_s;

  logic [ADDR_W-1:0]   addr_q;
  logic [MEM_BITS-1:0] mem_q;
  logic                wr_active, wr_done, wr_val_q;
  logic                in_map, cmp_zone, rd_ok, prog_ok, ers_ok;
  logic                step, wr_start, cmp_hit, commit, mem_bit, cmp_miss_q;

  assign wr_start = clk_rise && pgm_s && !rst_s;
  assign step     = clk_fall && !rst_s && !pgm_s && !wr_active;
  assign cmp_hit  = clk_rise && !pgm_s && !rst_s && cmp_zone;

  secmem_addr_ctr #(.MAX_ADDR(MAX_ADDR)) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(rst_fall),
    .step_i (step),
    .addr_o (addr_q)
  );

  secmem_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (wr_start),
    .tick_i  (clk_s),
    .stop_i  (clk_fall),
    .abort_i (rst_s),
    .active_o(wr_active),
    .done_o  (wr_done)
  );

  secmem_access_map #(.ADDR_W(ADDR_W)) u_map (
    .addr_i    (addr_q),
    .pers_i    (personalized_i),
    .code_i    (code_ok_i),
    .ekey_i    (erase_ok_i),
    .prot_bit_i(mem_q[PROT_BIT]),
    .rden_bit_i(mem_q[RDEN_BIT]),
    .in_map_o  (in_map),
    .cmp_zone_o(cmp_zone),
    .rd_ok_o   (rd_ok),
    .prog_ok_o (prog_ok),
    .ers_ok_o  (ers_ok)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       wr_val_q <= 1'b1;
    else if (wr_start) wr_val_q <= io_s;
  end

  assign commit = clk_fall && wr_active && wr_done && !rst_s && in_map &&
                  (wr_val_q ? ers_ok : prog_ok);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mem_q <= '1;
    else if (commit) mem_q[addr_q] <= wr_val_q;
  end

  assign mem_bit = in_map ? mem_q[addr_q] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cmp_miss_q <= 1'b0;
    else if (rst_fall)                    cmp_miss_q <= 1'b0;
    else if (cmp_hit && io_s != mem_bit)  cmp_miss_q <= 1'b1;
  end

  assign io_oe_o    = rd_ok;
  assign io_o       = rd_ok ? mem_bit : 1'b1;
  assign cmp_miss_o = cmp_miss_q;

endmodule

// File: rtl/secmem_chk.sv
module secmem_chk #(
  parameter int unsigned ADDR_W   = 11,
  parameter int unsigned MEM_BITS = 1376,
  parameter int unsigned MAX_ADDR = 1519
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                rst_s_i,
  input logic                rst_fall_i,
  input logic                clk_fall_i,
  input logic                step_i,
  input logic                wr_active_i,
  input logic                wr_done_i,
  input logic                cmp_hit_i,
  input logic                io_s_i,
  input logic                mem_bit_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [MEM_BITS-1:0] mem_i,
  input logic                io_i,
  input logic                io_oe_i,
  input logic                cmp_miss_i
);

  localparam logic [ADDR_W-1:0] TOP = ADDR_W'(MAX_ADDR);

  p_clear_on_fall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_fall_i |=> (addr_i == '0 && !cmp_miss_i));

  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !rst_fall_i && addr_i != TOP) |=> addr_i == $past(addr_i) + 1'b1);

  p_frozen_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_s_i |=> $stable(addr_i));

  p_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !rst_fall_i && addr_i == TOP) |=> addr_i == '0);

  p_released_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(addr_i) >= MEM_BITS) |-> (!io_oe_i && io_i));

  p_write_holds_addr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_fall_i && wr_active_i) |=> $stable(addr_i));

  p_early_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_fall_i && wr_active_i && !wr_done_i) |=> $stable(mem_i));

  p_miss_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_hit_i && !rst_fall_i && io_s_i != mem_bit_i) |=> cmp_miss_i);

endmodule

bind serial_secmem_ctrl secmem_chk #(
  .ADDR_W  (ADDR_W),
  .MEM_BITS(MEM_BITS),
  .MAX_ADDR(MAX_ADDR)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rst_s_i    (rst_s),
  .rst_fall_i (rst_fall),
  .clk_fall_i (clk_fall),
  .step_i     (step),
  .wr_active_i(wr_active),
  .wr_done_i  (wr_done),
  .cmp_hit_i  (cmp_hit),
  .io_s_i     (io_s),
  .mem_bit_i  (mem_bit),
  .addr_i     (addr_q),
  .mem_i      (mem_q),
  .io_i       (io_o),
  .io_oe_i    (io_oe_o),
  .cmp_miss_i (cmp_miss_o)
);

// File: tb/tb_serial_secmem_ctrl.sv
module tb_serial_secmem_ctrl;

  localparam int PROG = 40;
  localparam int LAST = 1519;
  localparam int NBITS = 1376;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic p_rst = 1'b0, p_clk = 1'b0, p_pgm = 1'b0, p_io = 1'b1;
  logic pers = 1'b0, code = 1'b0, ekey = 1'b0;
  logic io, oe, miss;

  always #2.5 clk = ~clk;

  serial_secmem_ctrl #(.PROG_CYCLES(PROG)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .pad_rst_i(p_rst), .pad_clk_i(p_clk), .pad_pgm_i(p_pgm), .pad_io_i(p_io),
    .personalized_i(pers), .code_ok_i(code), .erase_ok_i(ekey),
    .io_o(io), .io_oe_o(oe), .cmp_miss_o(miss)
  );

  int tests = 0, fails = 0;
  bit finished = 0;
  bit mm [0:NBITS-1];
  int ma = 0;
  bit mmiss = 0;
  logic cmp_io = 1'b1;

  // zone codes: 0 fab,1 iss,2 code,3 try,4 cpz,5 app,6 key,7 erc,8 tst,9 none
  function automatic int zone(input int a);
    if (a < 16) return 0;
    if (a < 80) return 1;
    if (a < 96) return 2;
    if (a < 112) return 3;
    if (a < 176) return 4;
    if (a < 1200) return 5;
    if (a < 1232) return 6;
    if (a < 1360) return 7;
    if (a < 1376) return 8;
    return 9;
  endfunction

  function automatic bit can_read(input int a);
    case (zone(a))
      2, 6: return !pers && code;
      5: return code || (pers && mm[177]);
      9: return 0;
      default: return 1;
    endcase
  endfunction

  function automatic bit can_write(input int a, input bit v);
    case (zone(a))
      0: return 0;
      1, 6: return !pers && code;
      2, 4: return code;
      3: return v ? code : 1'b1;
      5: return v ? (code && (!pers || ekey)) : (code && (!pers || mm[176]));
      7: return v ? (!pers && code) : 1'b1;
      8: return 1;
      default: return 0;
    endcase
  endfunction

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pads(input logic r, input logic c, input logic g, input logic d);
    p_rst = r; p_clk = c; p_pgm = g; p_io = d;
    settle();
  endtask

  task automatic check(input string tag);
    bit eo, ei;
    eo = can_read(ma);
    ei = eo ? mm[ma] : 1'b1;
    tests++;
    if (oe !== eo || io !== ei || miss !== mmiss) begin
      fails++;
      $display("FAIL %s addr=%0d actual oe/io/miss=%b%b%b expected=%b%b%b",
               tag, ma, oe, io, miss, eo, ei, mmiss);
    end
  endtask

  task automatic pad_reset();
    pads(1, 0, 0, 1);
    pads(0, 0, 0, 1);
    ma = 0; mmiss = 0;
  endtask

  task automatic inc1();
    pads(0, 1, 0, cmp_io);
    if ((zone(ma) == 2 || zone(ma) == 6) && cmp_io != mm[ma]) mmiss = 1;
    pads(0, 0, 0, 1);
    ma = (ma == LAST) ? 0 : ma + 1;
  endtask

  task automatic goto(input int a);
    while (ma != a) inc1();
  endtask

  task automatic wr(input bit v, input int hold);
    bit ok;
    ok = can_write(ma, v);
    pads(0, 0, 1, v);
    p_clk = 1'b1;
    repeat (hold) @(posedge clk);
    @(negedge clk);
    pads(0, 0, 1, v);
    pads(0, 0, 0, 1);
    if (hold >= PROG + 5 && ok) mm[ma] = v;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL R3 watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < NBITS; i++) mm[i] = 1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    settle();
    check("R1 reset state");

    // issuer-zone pattern: zeros at 17,24,30,31
    code = 1;
    goto(16);
    for (int a = 16; a < 42; a++) begin
      if (a == 17 || a == 24 || a == 30 || a == 31) begin
        wr(0, PROG + 10);
        check("R8 program");
      end
      inc1();
      check("R3 step");
    end

    // R4: pulses while reset pad high
    pad_reset();
    goto(24);
    pads(1, 0, 0, 1);
    for (int k = 0; k < 3; k++) begin
      pads(1, 1, 0, 1);
      pads(1, 0, 0, 1);
    end
    check("R4 hold in reset");
    pads(0, 0, 0, 1);
    ma = 0;
    check("R2 clear");
    goto(17);
    check("R2 cleared then stepped");

    // R9 / R8 on cell 18
    inc1();
    wr(0, PROG / 2 - 5);
    check("R9 short write");
    wr(0, PROG + 10);
    check("R8 long program");
    wr(1, PROG + 10);
    check("R8 erase");

    // R10 fabrication zone and issuer without code
    pad_reset();
    goto(3);
    wr(0, PROG + 10);
    check("R10 fab locked");
    goto(19);
    code = 0;
    wr(0, PROG + 10);
    check("R10 issuer needs code");
    code = 1;

    // R7 code zone, R11 compare
    goto(80);
    check("R7 code readable in perso");
    code = 0;
    settle();
    check("R7 code hidden");
    cmp_io = 0;
    inc1();
    cmp_io = 1;
    check("R11 miss set");
    goto(96);
    check("R11 miss sticky");
    pad_reset();
    check("R11 miss cleared");
    goto(112);
    check("R11 match no miss");

    // application zone
    goto(176);
    check("R7 app hidden");
    code = 1; settle();
    check("R7 app with code");
    pers = 1; code = 0; settle();
    check("R7 app read-enable bit");
    code = 1;
    inc1();
    wr(0, PROG + 10);
    check("R10 program rden cell");
    code = 0; settle();
    check("R7 app closed by rden=0");
    code = 1; settle();
    wr(1, PROG + 10);
    check("R10 erase without key");
    ekey = 1;
    wr(1, PROG + 10);
    check("R10 erase with key");
    ekey = 0;
    pad_reset();
    goto(176);
    wr(0, PROG + 10);
    check("R10 set protect");
    goto(178);
    wr(0, PROG + 10);
    check("R10 protected program");
    code = 0; pers = 0; settle();

    // map end and wrap
    goto(1375);
    check("R6 last mapped");
    inc1();
    check("R6 beyond map");
    goto(LAST);
    check("R6 top address");
    inc1();
    check("R5 wrap");

    // random phase
    for (int n = 0; n < 120; n++) begin
      int r;
      r = $urandom % 10;
      if (r == 0) begin
        pad_reset();
        check("R2 random reset");
      end else if (r <= 5) begin
        int c;
        c = 1 + $urandom % 6;
        for (int k = 0; k < c; k++) begin
          cmp_io = 1'($urandom % 4 != 0);
          inc1();
        end
        cmp_io = 1;
        check("R3 random step");
      end else if (r <= 7) begin
        bit v;
        v = 1'($urandom % 2);
        wr(v, ($urandom % 2) ? PROG + 10 : PROG / 2 - 5);
        check("R10 random write");
      end else begin
        pers = 1'($urandom % 2);
        code = 1'($urandom % 2);
        ekey = 1'($urandom % 2);
        settle();
        check("R7 random flags");
      end
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule